// File: doc/BRIEF.md
# Bidirectional I/O Port with Peripheral Override

This block controls an eight-pin bidirectional port. Software reaches it over a small register bus and can set a per-pin direction mask, write an output latch, and read back the latch, the direction mask or the current pad levels. For each pin the block decides who drives the pad. The candidates are the latch, a compare/PWM unit, a serial peripheral and a UART. It then produces the pad output-enable and output-data levels.

Any peripheral that turns on its output function for a pin takes over that pin. It forces the pin to output and supplies the drive value, with a fixed priority between peripherals. A peripheral can also force a pin to input. The direction register always reads back what software last wrote, never the effective direction. Each of the three peripheral functions has its own open-drain control. The compare/PWM drive can release the pad during a PWM shutdown event. A configuration input decides whether the second compare/PWM channel reaches pin 1.

Pad levels pass through a two-flop synchronizer before they reach the port read path or the capture input. The register bus is a valid/ready request channel. `bus_ready` is held high, so every request is taken in the cycle `bus_valid` is high, and there is no back-pressure. A read answers on `rd_valid`/`rd_data` in the cycle after it is accepted. The response channel has no ready signal, so the requester must always take it.

Top module: `gpio_override_port`

## Requirements
- R1: With no peripheral output or force active on a pin, the pin is driven (`pad_oe`=1, `pad_out` = latch bit) when its direction bit is 0, and released (`pad_oe`=0) when its direction bit is 1.
- R2: After reset the direction register is all ones, the latch is all zeros and every `pad_oe` bit is 0.
- R3: A write to address 0 (port) or address 1 (latch) loads the latch. Reading address 1 returns the latch. A write to address 3 changes nothing, and reading address 3 returns 0.
- R4: A request is accepted in any cycle `bus_valid` is high. A read accepted at a clock edge raises `rd_valid` with its data after that same edge. Reading address 0 returns the synchronized pad levels.
- R5: Reading address 2 returns the last written direction value, even while peripherals override pin directions.
- R6: An active peripheral output forces its pin to output. When several are active on one pin, compare/PWM wins over serial, serial wins over UART, and UART wins over the latch.
- R7: `force_in` bit set releases that pin (`pad_oe`=0) when no peripheral output is active on it, whatever its direction bit.
- R8: When a peripheral wins a pin and that peripheral's open-drain input (`od_ccp`, `od_spi`, `od_uart`) is 1, the pin drives 0 with `pad_oe`=1 for a value of 0 and is released for a value of 1. The open-drain input of one function does not affect pins won by another function.
- R9: While `pwm_shutdown` and `pwm_sd_tristate` are both 1, every pin won by compare/PWM has `pad_oe`=0. With `pwm_sd_tristate`=0 the compare/PWM drive continues.
- R10: With `ccp2_map`=1, compare/PWM can drive pin 1. With `ccp2_map`=0, its enable on pin 1 is ignored and pin 1 falls to the next source.
- R11: `cap_in` bit i equals the synchronized pad level when direction bit i is 1, and 0 when it is 0.
- R12: A pad change applied before clock edge k shows on `cap_in` after edge k+1. A port read accepted at edge k+2 returns it, while reads accepted at edges k and k+1 return the old level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Register request valid |
| bus_ready | output | 1 | Request accepted (always 1) |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | 0 port, 1 latch, 2 direction, 3 unused |
| bus_wdata | input | 8 | Write data |
| rd_valid | output | 1 | Read response valid |
| rd_data | output | 8 | Read response data |
| ccp_en | input | 8 | Compare/PWM output function active per pin |
| ccp_out | input | 8 | Compare/PWM drive value per pin |
| spi_en | input | 8 | Serial output function active per pin |
| spi_out | input | 8 | Serial drive value per pin |
| uart_en | input | 8 | UART output function active per pin |
| uart_out | input | 8 | UART drive value per pin |
| force_in | input | 8 | Peripheral forces pin to input |
| od_ccp | input | 1 | Open-drain for compare/PWM drive |
| od_spi | input | 1 | Open-drain for serial drive |
| od_uart | input | 1 | Open-drain for UART drive |
| pwm_shutdown | input | 1 | PWM shutdown event active |
| pwm_sd_tristate | input | 1 | Release PWM pins during shutdown |
| ccp2_map | input | 1 | Route second compare/PWM channel to pin 1 |
| pad_in | input | 8 | Pad input levels (asynchronous) |
| pad_oe | output | 8 | Pad output enable |
| pad_out | output | 8 | Pad output data |
| cap_in | output | 8 | Synchronized capture input to compare/PWM |

## Verification
The pad outputs respond combinationally to the peripheral inputs, and to the latch and direction registers one edge after a write. The bench therefore checks `pad_oe`/`pad_out` at the falling edge that follows the write or the input change. Read data is registered, so each read is checked at the falling edge after its accepting rising edge. Pad input changes take two edges through the synchronizer. The bench holds a port read for three successive edges and expects the old level, the old level and then the new level. It checks `cap_in` one falling edge before the new level would appear on a read.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  typedef enum logic [1:0] {
    REG_PORT = 2'd0,
    REG_LAT  = 2'd1,
    REG_DIR  = 2'd2,
    REG_NONE = 2'd3
  } reg_sel_e;

  typedef enum logic [1:0] {
    SRC_LATCH = 2'd0,
    SRC_CCP   = 2'd1,
    SRC_SPI   = 2'd2,
    SRC_UART  = 2'd3
  } drv_src_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  logic [WIDTH-1:0] stage1_q, stage2_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= async_in;
      stage2_q <= stage1_q;
    end
  end

  assign sync_out = stage2_q;

  // cycles since reset release, for the latency check only
  logic [1:0] warm_q;
  always_ff @(posedge clk) begin
    if (!rst_n) warm_q <= '0;
    else if (warm_q != 2'd2) warm_q <= warm_q + 2'd1;
  end

  a_r12_two_edge_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (warm_q == 2'd2) |-> (sync_out == $past(async_in, 2)));
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_port_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_valid,
  input  logic             bus_write,
  input  logic [1:0]       bus_addr,
  input  logic [WIDTH-1:0] bus_wdata,
  input  logic [WIDTH-1:0] pin_sync,
  output logic [WIDTH-1:0] lat_q,
  output logic [WIDTH-1:0] dir_q,
  output logic             rd_valid,
  output logic [WIDTH-1:0] rd_data
);
  reg_sel_e         sel;
  logic             wr_go, rd_go;
  logic [WIDTH-1:0] rd_mux;

  assign sel   = reg_sel_e'(bus_addr);
  assign wr_go = bus_valid & bus_write;
  assign rd_go = bus_valid & ~bus_write;

  always_comb begin
    unique case (sel)
      REG_PORT: rd_mux = pin_sync;
      REG_LAT:  rd_mux = lat_q;
      REG_DIR:  rd_mux = dir_q;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lat_q    <= '0;
      dir_q    <= '1;
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_go;
      if (rd_go) rd_data <= rd_mux;
      if (wr_go) begin
        unique case (sel)
          REG_PORT, REG_LAT: lat_q <= bus_wdata;
          REG_DIR:           dir_q <= bus_wdata;
          default:           ;
        endcase
      end
    end
  end

  a_r2_reset_values: assert property (@(posedge clk)
    !rst_n |=> (dir_q == '1 && lat_q == '0));
  a_r3_latch_load: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_go && (bus_addr == 2'd0 || bus_addr == 2'd1)) |=> (lat_q == $past(bus_wdata)));
  a_r5_dir_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_go && bus_addr == 2'd2) |=> $stable(dir_q));
  a_r4_read_answers: assert property (@(posedge clk) disable iff (!rst_n)
    rd_go |=> rd_valid);
endmodule

// File: rtl/gpio_pin_mux.sv
module gpio_pin_mux
  import gpio_port_pkg::*;
#(
  parameter int WIDTH    = 8,
  parameter int CCP2_PIN = 1
) (
  input  logic [WIDTH-1:0] lat_q,
  input  logic [WIDTH-1:0] dir_q,
  input  logic [WIDTH-1:0] ccp_en,
  input  logic [WIDTH-1:0] ccp_out,
  input  logic [WIDTH-1:0] spi_en,
  input  logic [WIDTH-1:0] spi_out,
  input  logic [WIDTH-1:0] uart_en,
  input  logic [WIDTH-1:0] uart_out,
  input  logic [WIDTH-1:0] force_in,
  input  logic             od_ccp,
  input  logic             od_spi,
  input  logic             od_uart,
  input  logic             pwm_shutdown,
  input  logic             pwm_sd_tristate,
  input  logic             ccp2_map,
  output logic [WIDTH-1:0] pad_oe,
  output logic [WIDTH-1:0] pad_out
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_pin
    logic     ccp_live;
    drv_src_e src;
    logic     val;
    logic     od;

    if (i == CCP2_PIN) begin : g_mapped
      assign ccp_live = ccp_en[i] & ccp2_map;
    end else begin : g_fixed
      assign ccp_live = ccp_en[i];
    end

    always_comb begin
      if (ccp_live)        src = SRC_CCP;
      else if (spi_en[i])  src = SRC_SPI;
      else if (uart_en[i]) src = SRC_UART;
      else                 src = SRC_LATCH;
    end

    always_comb begin
      unique case (src)
        SRC_CCP:  begin val = ccp_out[i];  od = od_ccp;  end
        SRC_SPI:  begin val = spi_out[i];  od = od_spi;  end
        SRC_UART: begin val = uart_out[i]; od = od_uart; end
        default:  begin val = lat_q[i];    od = 1'b0;    end
      endcase
    end

    always_comb begin
      if (src == SRC_LATCH) begin
        pad_oe[i]  = ~dir_q[i] & ~force_in[i];
        pad_out[i] = val;
      end else if (src == SRC_CCP && pwm_shutdown && pwm_sd_tristate) begin
        pad_oe[i]  = 1'b0;
        pad_out[i] = 1'b0;
      end else if (od) begin
        pad_oe[i]  = ~val;
        pad_out[i] = 1'b0;
      end else begin
        pad_oe[i]  = 1'b1;
        pad_out[i] = val;
      end
    end
  end
endmodule

// File: rtl/gpio_override_port.sv
module gpio_override_port
  import gpio_port_pkg::*;
#(
  parameter int WIDTH    = 8,
  parameter int CCP2_PIN = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_valid,
  output logic             bus_ready,
  input  logic             bus_write,
  input  logic [1:0]       bus_addr,
  input  logic [WIDTH-1:0] bus_wdata,
  output logic             rd_valid,
  output logic [WIDTH-1:0] rd_data,
  input  logic [WIDTH-1:0] ccp_en,
  input  logic [WIDTH-1:0] ccp_out,
  input  logic [WIDTH-1:0] spi_en,
  input  logic [WIDTH-1:0] spi_out,
  input  logic [WIDTH-1:0] uart_en,
  input  logic [WIDTH-1:0] uart_out,
  input  logic [WIDTH-1:0] force_in,
  input  logic             od_ccp,
  input  logic             od_spi,
  input  logic             od_uart,
  input  logic             pwm_shutdown,
  input  logic             pwm_sd_tristate,
  input  logic             ccp2_map,
  input  logic [WIDTH-1:0] pad_in,
  output logic [WIDTH-1:0] pad_oe,
  output logic [WIDTH-1:0] pad_out,
  output logic [WIDTH-1:0] cap_in
);
  localparam logic [WIDTH-1:0] CCP2_MASK = WIDTH'(1) << CCP2_PIN;

  logic [WIDTH-1:0] pin_sync, lat_q, dir_q;

  assign bus_ready = 1'b1;

  gpio_sync #(.WIDTH(WIDTH)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(pad_in), .sync_out(pin_sync)
  );

  gpio_regs #(.WIDTH(WIDTH)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .pin_sync(pin_sync), .lat_q(lat_q), .dir_q(dir_q),
    .rd_valid(rd_valid), .rd_data(rd_data)
  );

  gpio_pin_mux #(.WIDTH(WIDTH), .CCP2_PIN(CCP2_PIN)) u_mux (
    .lat_q(lat_q), .dir_q(dir_q),
    .ccp_en(ccp_en), .ccp_out(ccp_out),
    .spi_en(spi_en), .spi_out(spi_out),
    .uart_en(uart_en), .uart_out(uart_out),
    .force_in(force_in),
    .od_ccp(od_ccp), .od_spi(od_spi), .od_uart(od_uart),
    .pwm_shutdown(pwm_shutdown), .pwm_sd_tristate(pwm_sd_tristate),
    .ccp2_map(ccp2_map),
    .pad_oe(pad_oe), .pad_out(pad_out)
  );

  assign cap_in = pin_sync & dir_q;

  a_r9_shutdown_release: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm_shutdown && pwm_sd_tristate) |->
      ((pad_oe & ccp_en & ~(ccp2_map ? '0 : CCP2_MASK)) == '0));
  a_r1_plain_direction: assert property (@(posedge clk) disable iff (!rst_n)
    ((ccp_en | spi_en | uart_en | force_in) == '0) |-> (pad_oe == ~dir_q));
  a_r2_quiet_after_reset: assert property (@(posedge clk)
    !rst_n |=> ((ccp_en | spi_en | uart_en) != '0 || pad_oe == '0));
endmodule

// File: tb/sim_gpio_override_port.sv
module sim_gpio_override_port;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_valid = 1'b0, bus_write = 1'b0;
  logic [1:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic bus_ready, rd_valid;
  logic [7:0] rd_data;
  logic [7:0] ccp_en = '0, ccp_out = '0, spi_en = '0, spi_out = '0;
  logic [7:0] uart_en = '0, uart_out = '0, force_in = '0, pad_in = '0;
  logic od_ccp = 1'b0, od_spi = 1'b0, od_uart = 1'b0;
  logic pwm_shutdown = 1'b0, pwm_sd_tristate = 1'b0, ccp2_map = 1'b1;
  logic [7:0] pad_oe, pad_out, cap_in;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  gpio_override_port u0 (.*);

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_valid = 1'b0;
    check("R4 rd_valid", {7'd0, rd_valid}, 8'd1);
    d = rd_data;
  endtask

  task automatic clear_periph();
    @(negedge clk);
    ccp_en = '0; ccp_out = '0; spi_en = '0; spi_out = '0;
    uart_en = '0; uart_out = '0; force_in = '0;
    od_ccp = 0; od_spi = 0; od_uart = 0;
    pwm_shutdown = 0; pwm_sd_tristate = 0; ccp2_map = 1;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    check("R2 pad_oe", pad_oe, 8'h00);
    check("R4 bus_ready", {7'd0, bus_ready}, 8'd1);
    rd(2'd2, v); check("R2 dir reset", v, 8'hFF);
    rd(2'd1, v); check("R2 latch reset", v, 8'h00);
  endtask

  task automatic t_sync();
    @(negedge clk);
    pad_in = 8'h5A; bus_valid = 1'b1; bus_write = 1'b0; bus_addr = 2'd0;
    @(negedge clk); check("R12 read at edge k", rd_data, 8'h00);
    check("R11 cap before", cap_in, 8'h00);
    @(negedge clk); check("R12 read at edge k+1", rd_data, 8'h00);
    check("R12 cap after k+1", cap_in, 8'h5A);
    @(negedge clk); check("R4 R12 read at edge k+2", rd_data, 8'h5A);
    bus_valid = 1'b0;
  endtask

  task automatic t_latch();
    logic [7:0] v;
    wr(2'd1, 8'hA5); rd(2'd1, v); check("R3 latch addr", v, 8'hA5);
    wr(2'd0, 8'h3C); rd(2'd1, v); check("R3 port addr writes latch", v, 8'h3C);
    wr(2'd3, 8'hFF); rd(2'd1, v); check("R3 addr3 write ignored", v, 8'h3C);
    rd(2'd3, v); check("R3 addr3 reads zero", v, 8'h00);
    wr(2'd2, 8'hCF);
    check("R1 oe from dir", pad_oe, 8'h30);
    check("R1 out from latch", pad_out & pad_oe, 8'h30);
    rd(2'd2, v); check("R5 dir readback", v, 8'hCF);
  endtask

  task automatic t_override();
    logic [7:0] v;
    wr(2'd2, 8'hFF); wr(2'd1, 8'h00);
    @(negedge clk); ccp_en = 8'h04; ccp_out = 8'h04;
    #1 check("R6 ccp forces output", pad_oe, 8'h04);
    check("R6 ccp drive", pad_out & 8'h04, 8'h04);
    rd(2'd2, v); check("R5 dir unaffected", v, 8'hFF);
    clear_periph();
    ccp_en = 8'h01; ccp_out = 8'h00;
    spi_en = 8'h01; spi_out = 8'h01;
    uart_en = 8'h03; uart_out = 8'h03;
    #1 check("R6 oe priority", pad_oe, 8'h03);
    check("R6 ccp over spi, uart alone", pad_out & 8'h03, 8'h02);
    spi_en = 8'h02; spi_out = 8'h00;
    #1 check("R6 spi over uart", pad_out & 8'h03, 8'h00);
    clear_periph();
  endtask

  task automatic t_force();
    logic [7:0] v;
    wr(2'd2, 8'h00);
    @(negedge clk); force_in = 8'h80;
    #1 check("R7 force input", pad_oe, 8'h7F);
    rd(2'd2, v); check("R5 dir while forced", v, 8'h00);
    @(negedge clk); uart_en = 8'h80; uart_out = 8'h80;
    #1 check("R7 peripheral beats force", pad_oe, 8'hFF);
    clear_periph();
    wr(2'd2, 8'hFF);
  endtask

  task automatic t_od();
    @(negedge clk); ccp_en = 8'h04; ccp_out = 8'h04; od_ccp = 1;
    spi_en = 8'h08; spi_out = 8'h08;
    #1 check("R8 ccp od releases 1", pad_oe & 8'h04, 8'h00);
    check("R8 spi push-pull", {pad_oe[3], pad_out[3]}, 8'h03);
    @(negedge clk); ccp_out = 8'h00;
    #1 check("R8 ccp od drives 0", {pad_oe[2], pad_out[2]}, 8'h02);
    @(negedge clk); od_spi = 1; od_ccp = 0; ccp_out = 8'h04;
    #1 check("R8 spi od releases 1", pad_oe & 8'h08, 8'h00);
    check("R8 ccp push-pull unaffected", {pad_oe[2], pad_out[2]}, 8'h03);
    clear_periph();
  endtask

  task automatic t_shutdown();
    @(negedge clk); ccp_en = 8'h04; ccp_out = 8'h04; pwm_shutdown = 1; pwm_sd_tristate = 1;
    #1 check("R9 shutdown tristate", pad_oe, 8'h00);
    @(negedge clk); pwm_sd_tristate = 0;
    #1 check("R9 shutdown no tristate", pad_oe, 8'h04);
    clear_periph();
  endtask

  task automatic t_map();
    @(negedge clk); ccp_en = 8'h02; ccp_out = 8'h02; ccp2_map = 1;
    #1 check("R10 mapped drives pin1", {pad_oe[1], pad_out[1]}, 8'h03);
    @(negedge clk); ccp2_map = 0;
    #1 check("R10 unmapped pin1 released", pad_oe, 8'h00);
    @(negedge clk); uart_en = 8'h02; uart_out = 8'h00;
    #1 check("R10 pin1 falls to uart", {pad_oe[1], pad_out[1]}, 8'h02);
    clear_periph();
  endtask

  task automatic t_capture();
    wr(2'd2, 8'h0F);
    @(negedge clk); pad_in = 8'hFF;
    repeat (3) @(negedge clk);
    check("R11 capture masked by dir", cap_in, 8'h0F);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_sync();
    t_latch();
    t_override();
    t_force();
    t_od();
    t_shutdown();
    t_map();
    t_capture();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule